// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block performs the hardware side of taking an interrupt on a segmented 16-bit processor. A request strobe arrives with a set of cause inputs: divide error, overflow trap, breakpoint, non-maskable input and an external type number. Alongside them come the current flags word, code segment, instruction pointer, stack segment and stack pointer. The block picks one 8-bit type number. It saves the return context on the stack as three word writes, then fetches the handler's instruction pointer and code segment from the vector table.

All memory traffic goes through one word-wide port with a valid/ready handshake, and the sequencer waits in each step until that step is accepted. When the fetch completes, the block raises a one-cycle done pulse. At that point the core can take the new code segment, the instruction pointer, the updated stack pointer and the flags word with interrupt-enable and single-step cleared.

Top module: `int_entry_seq`

## Requirements
- R1: When `req` is sampled high while idle, the type is chosen by fixed priority: divide error (type 0), then overflow trap (type 4), then breakpoint (type 3), then non-maskable input (type 2), then the external request (type `ext_type`). The chosen type appears on `entry_type`.
- R2: The overflow-trap cause counts only when bit 11 (overflow) of `flags_in` is 1. With bit 11 clear it is ignored. A request whose only cause is an ignored overflow trap starts no entry: `busy` and `mem_valid` stay low.
- R3: The first three memory transfers of an entry are writes (`mem_we`=1) of the flags word, then the code segment, then the instruction pointer, all as they were sampled with the request.
- R4: Before each of the three writes the stack pointer is lowered by 2, modulo 2^16. The write address is stack segment × 16 plus that pointer, modulo 2^20. `new_sp` equals the sampled stack pointer minus 6.
- R5: After the writes, two reads (`mem_we`=0) follow. The read at address type × 4 supplies `new_ip`, and the read at type × 4 + 2 supplies `new_cs`.
- R6: `new_flags` equals the sampled flags with bit 9 (interrupt enable) and bit 8 (single-step trap) cleared and every other bit unchanged.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` hold their values. Each accepted handshake completes exactly one transfer.
- R8: `done` is high for exactly one cycle, in the cycle after the final read is accepted, with `new_ip` and `new_cs` already valid. `mem_valid` is low whenever `done` is high.
- R9: After reset, `busy`, `mem_valid` and `done` are 0.
- R10: A request made while `busy` is high is ignored: the entry in progress completes with its original type and context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe; causes are sampled with it |
| exc_div0 | input | 1 | Divide-error cause |
| exc_ovf | input | 1 | Overflow-trap cause (qualified by flags bit 11) |
| exc_brk | input | 1 | Breakpoint cause |
| nmi | input | 1 | Non-maskable input cause |
| ext_req | input | 1 | External cause using `ext_type` |
| ext_type | input | 8 | Type number supplied externally |
| flags_in | input | 16 | Current flags word |
| cs_in | input | 16 | Return code segment |
| ip_in | input | 16 | Return instruction pointer |
| ss_in | input | 16 | Stack segment |
| sp_in | input | 16 | Stack pointer |
| mem_ready | input | 1 | Memory accepts the current transfer |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` on reads |
| busy | output | 1 | Entry in progress |
| mem_valid | output | 1 | Transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Byte address |
| mem_wdata | output | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| entry_type | output | 8 | Selected type number |
| new_ip | output | 16 | Handler instruction pointer |
| new_cs | output | 16 | Handler code segment |
| new_flags | output | 16 | Flags with enable and trap cleared |
| new_sp | output | 16 | Stack pointer after the three pushes |

## Verification
Some properties hold on every cycle, and the checker covers them. A stalled transfer keeps its address, direction and data steady. Every read falls on an even address inside the 1 KiB vector table. `done` never lasts two cycles and never coincides with a memory request, and the flags output carries cleared enable and trap bits whenever `done` is high. Other behaviour can only be shown by the bench's directed scenarios, which compare results against values computed independently: the cause priority, the qualification of the overflow trap, the order and contents of the three pushes, stack-pointer wraparound in both the pointer and the 20-bit address, the vector values returned, and the rejection of requests made while busy.

// File: rtl/int_entry_pkg.sv
package int_entry_pkg;

    // Flag bit positions within the 16-bit flags word
    localparam int OF_BIT = 11;
    localparam int IE_BIT = 9;
    localparam int TF_BIT = 8;

    localparam int TYPE_W = 8;

    // Dedicated type numbers
    localparam logic [TYPE_W-1:0] T_DIV0 = 8'd0;
    localparam logic [TYPE_W-1:0] T_NMI  = 8'd2;
    localparam logic [TYPE_W-1:0] T_BRK  = 8'd3;
    localparam logic [TYPE_W-1:0] T_OVF  = 8'd4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH_FL,
        S_PUSH_CS,
        S_PUSH_IP,
        S_RD_IP,
        S_RD_CS
    } seq_state_e;

    typedef struct packed {
        logic              hit;
        logic [TYPE_W-1:0] num;
    } cause_t;

    function automatic logic is_push(input seq_state_e s);
        return (s == S_PUSH_FL) || (s == S_PUSH_CS) || (s == S_PUSH_IP);
    endfunction

endpackage

// File: rtl/int_cause_sel.sv
module int_cause_sel
    import int_entry_pkg::*;
(
    input  logic              div0,
    input  logic              ovf,
    input  logic              of_flag,
    input  logic              brk,
    input  logic              nmi,
    input  logic              ext,
    input  logic [TYPE_W-1:0] ext_type,
    output cause_t            sel
);
    always_comb begin
        sel = '{hit: 1'b1, num: T_DIV0};
        if (div0)               sel.num = T_DIV0;
        else if (ovf && of_flag) sel.num = T_OVF;
        else if (brk)           sel.num = T_BRK;
        else if (nmi)           sel.num = T_NMI;
        else if (ext)           sel.num = ext_type;
        else                    sel.hit = 1'b0;
    end
endmodule

// File: rtl/int_addr_gen.sv
module int_addr_gen
    import int_entry_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int SEG_SHIFT = 4,
    parameter int VEC_SHIFT = 2,
    localparam int PHYS_W   = WORD_W + SEG_SHIFT
) (
    input  seq_state_e        state,
    input  logic [WORD_W-1:0] ss,
    input  logic [WORD_W-1:0] sp_dec,
    input  logic [TYPE_W-1:0] vtype,
    output logic [PHYS_W-1:0] addr
);
    logic [PHYS_W-1:0] stack_addr;
    logic [PHYS_W-1:0] vec_base;

    assign stack_addr = {ss, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, sp_dec};
    assign vec_base   = {{(PHYS_W-TYPE_W-VEC_SHIFT){1'b0}}, vtype, {VEC_SHIFT{1'b0}}};

    always_comb begin
        if (is_push(state))           addr = stack_addr;
        else if (state == S_RD_CS)    addr = vec_base + PHYS_W'(2);
        else if (state == S_RD_IP)    addr = vec_base;
        else                          addr = '0;
    end
endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
    import int_entry_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PHYS_W   = WORD_W + SEG_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              exc_div0,
    input  logic              exc_ovf,
    input  logic              exc_brk,
    input  logic              nmi,
    input  logic              ext_req,
    input  logic [TYPE_W-1:0] ext_type,
    input  logic [WORD_W-1:0] flags_in,
    input  logic [WORD_W-1:0] cs_in,
    input  logic [WORD_W-1:0] ip_in,
    input  logic [WORD_W-1:0] ss_in,
    input  logic [WORD_W-1:0] sp_in,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [PHYS_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              done,
    output logic [TYPE_W-1:0] entry_type,
    output logic [WORD_W-1:0] new_ip,
    output logic [WORD_W-1:0] new_cs,
    output logic [WORD_W-1:0] new_flags,
    output logic [WORD_W-1:0] new_sp
);
    seq_state_e        state_q;
    cause_t            cause;
    logic [WORD_W-1:0] fl_q, cs_q, ip_q, ss_q, sp_q, sp_dec;
    logic [WORD_W-1:0] nip_q, ncs_q;
    logic [TYPE_W-1:0] type_q;
    logic              done_q;
    logic              accept, xfer;

    int_cause_sel u_cause (
        .div0     (exc_div0),
        .ovf      (exc_ovf),
        .of_flag  (flags_in[OF_BIT]),
        .brk      (exc_brk),
        .nmi      (nmi),
        .ext      (ext_req),
        .ext_type (ext_type),
        .sel      (cause)
    );

    assign sp_dec = sp_q - WORD_W'(2);

    int_addr_gen #(.WORD_W(WORD_W), .SEG_SHIFT(SEG_SHIFT)) u_addr (
        .state  (state_q),
        .ss     (ss_q),
        .sp_dec (sp_dec),
        .vtype  (type_q),
        .addr   (mem_addr)
    );

    assign accept    = (state_q == S_IDLE) && req && cause.hit;
    assign mem_valid = (state_q != S_IDLE);
    assign mem_we    = is_push(state_q);
    assign xfer      = mem_valid && mem_ready;
    assign busy      = mem_valid;

    always_comb begin
        case (state_q)
            S_PUSH_FL: mem_wdata = fl_q;
            S_PUSH_CS: mem_wdata = cs_q;
            S_PUSH_IP: mem_wdata = ip_q;
            default:   mem_wdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            done_q  <= 1'b0;
            fl_q    <= '0;
            cs_q    <= '0;
            ip_q    <= '0;
            ss_q    <= '0;
            sp_q    <= '0;
            nip_q   <= '0;
            ncs_q   <= '0;
            type_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: if (accept) begin
                    fl_q    <= flags_in;
                    cs_q    <= cs_in;
                    ip_q    <= ip_in;
                    ss_q    <= ss_in;
                    sp_q    <= sp_in;
                    type_q  <= cause.num;
                    state_q <= S_PUSH_FL;
                end
                S_PUSH_FL: if (xfer) begin
                    sp_q    <= sp_dec;
                    state_q <= S_PUSH_CS;
                end
                S_PUSH_CS: if (xfer) begin
                    sp_q    <= sp_dec;
                    state_q <= S_PUSH_IP;
                end
                S_PUSH_IP: if (xfer) begin
                    sp_q    <= sp_dec;
                    state_q <= S_RD_IP;
                end
                S_RD_IP: if (xfer) begin
                    nip_q   <= mem_rdata;
                    state_q <= S_RD_CS;
                end
                S_RD_CS: if (xfer) begin
                    ncs_q   <= mem_rdata;
                    done_q  <= 1'b1;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        new_flags         = fl_q;
        new_flags[IE_BIT] = 1'b0;
        new_flags[TF_BIT] = 1'b0;
    end

    assign done       = done_q;
    assign entry_type = type_q;
    assign new_ip     = nip_q;
    assign new_cs     = ncs_q;
    assign new_sp     = sp_q;
endmodule

// File: rtl/int_entry_chk.sv
module int_entry_chk #(
    parameter int WORD_W = 16,
    parameter int PHYS_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [PHYS_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              done,
    input logic [WORD_W-1:0] new_flags
);
    // R7: a stalled transfer keeps its request steady
    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_we) && $stable(mem_wdata));

    // R5: every vector read is an even address inside the 1 KiB table
    assert_vec_range_R5: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_we |-> (mem_addr < PHYS_W'(1024)) && !mem_addr[0]);

    // R8: done lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: no memory request while done is shown
    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_valid && !busy);

    // R6: enable and trap flags are cleared at completion
    assert_flags_clear_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> new_flags[9:8] == 2'b00);

    // R9: leaving reset the block is idle
    assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !mem_valid && !done && !busy);
endmodule

bind int_entry_seq int_entry_chk #(.WORD_W(WORD_W), .PHYS_W(PHYS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done),
    .new_flags (new_flags)
);

// File: tb/int_entry_seq_bench.sv
module int_entry_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        exc_div0 = 1'b0, exc_ovf = 1'b0, exc_brk = 1'b0, nmi = 1'b0, ext_req = 1'b0;
    logic [7:0]  ext_type = '0;
    logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0, ss_in = '0, sp_in = '0;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_rdata;
    logic        busy, mem_valid, mem_we, done;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, new_ip, new_cs, new_flags, new_sp;
    logic [7:0]  entry_type;

    int checks = 0;
    int errors = 0;
    int stall  = 0;
    int wcnt   = 0;

    logic        log_clr = 1'b0;
    int          log_n = 0;
    logic [19:0] log_addr [0:15];
    logic [15:0] log_data [0:15];
    logic        log_we   [0:15];

    always #4 clk = ~clk;

    int_entry_seq u_int_entry_seq (
        .clk(clk), .rst(rst), .req(req),
        .exc_div0(exc_div0), .exc_ovf(exc_ovf), .exc_brk(exc_brk), .nmi(nmi),
        .ext_req(ext_req), .ext_type(ext_type),
        .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in), .ss_in(ss_in), .sp_in(sp_in),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .busy(busy), .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done(done), .entry_type(entry_type),
        .new_ip(new_ip), .new_cs(new_cs), .new_flags(new_flags), .new_sp(new_sp)
    );

    function automatic logic [15:0] vec_word(input logic [19:0] widx);
        return 16'(widx * 20'h00123) ^ 16'h5A3C;
    endfunction

    function automatic logic [19:0] stk(input logic [15:0] ss, input logic [15:0] sp, input int k);
        logic [15:0] d;
        d = sp - 16'(2 * k);
        return {ss, 4'h0} + {4'h0, d};
    endfunction

    assign mem_rdata = vec_word({1'b0, mem_addr[19:1]});

    // Memory responder: ready after 'stall' waiting cycles
    always @(negedge clk) begin
        if (mem_valid && wcnt >= stall) begin
            mem_ready <= 1'b1;
            wcnt      <= 0;
        end else begin
            mem_ready <= 1'b0;
            if (mem_valid) wcnt <= wcnt + 1;
            else           wcnt <= 0;
        end
    end

    // Transfer log
    always @(posedge clk) begin
        if (log_clr) log_n <= 0;
        else if (mem_valid && mem_ready && log_n < 16) begin
            log_addr[log_n] <= mem_addr;
            log_data[log_n] <= mem_wdata;
            log_we[log_n]   <= mem_we;
            log_n           <= log_n + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_causes();
        req = 0; exc_div0 = 0; exc_ovf = 0; exc_brk = 0; nmi = 0; ext_req = 0;
    endtask

    task automatic run_entry(input string tag, input logic d0, input logic ov, input logic bk,
                             input logic nm, input logic ex, input logic [7:0] et,
                             input logic [15:0] fl, input logic [15:0] cs, input logic [15:0] ip,
                             input logic [15:0] ss, input logic [15:0] sp,
                             input logic [7:0] exp_type, input int st, input bit noise);
        int waited;
        @(negedge clk);
        stall = st; log_clr = 1;
        @(negedge clk);
        log_clr = 0;
        exc_div0 = d0; exc_ovf = ov; exc_brk = bk; nmi = nm; ext_req = ex; ext_type = et;
        flags_in = fl; cs_in = cs; ip_in = ip; ss_in = ss; sp_in = sp; req = 1;
        @(negedge clk);
        clear_causes();
        if (noise) begin
            // R10: competing requests while busy
            for (int i = 0; i < 6; i++) begin
                req = 1; ext_req = 1; ext_type = 8'h55; exc_brk = 1;
                flags_in = 16'hFFFF; cs_in = 16'h1111; ip_in = 16'h2222;
                ss_in = 16'h3333; sp_in = 16'h4444;
                @(negedge clk);
            end
            clear_causes();
        end
        waited = 0;
        while (!done && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        check({tag, " R8 done seen"}, {31'b0, done}, 32'd1);
        check({tag, " R1 entry_type"}, {24'b0, entry_type}, {24'b0, exp_type});
        check({tag, " R5 new_ip"}, {16'b0, new_ip}, {16'b0, vec_word({10'b0, exp_type, 2'b00} >> 1)});
        check({tag, " R5 new_cs"}, {16'b0, new_cs}, {16'b0, vec_word(({10'b0, exp_type, 2'b00} >> 1) + 1)});
        check({tag, " R6 new_flags"}, {16'b0, new_flags}, {16'b0, fl & 16'hFCFF});
        check({tag, " R4 new_sp"}, {16'b0, new_sp}, {16'b0, sp - 16'd6});
        check({tag, " R7 transfer count"}, log_n, 32'd5);
        for (int k = 0; k < 3; k++) begin
            check({tag, " R3 push is write"}, {31'b0, log_we[k]}, 32'd1);
            check({tag, " R4 push address"}, {12'b0, log_addr[k]}, {12'b0, stk(ss, sp, k + 1)});
        end
        check({tag, " R3 push flags"}, {16'b0, log_data[0]}, {16'b0, fl});
        check({tag, " R3 push cs"}, {16'b0, log_data[1]}, {16'b0, cs});
        check({tag, " R3 push ip"}, {16'b0, log_data[2]}, {16'b0, ip});
        check({tag, " R5 read ip dir"}, {31'b0, log_we[3]}, 32'd0);
        check({tag, " R5 read ip addr"}, {12'b0, log_addr[3]}, {22'b0, exp_type, 2'b00});
        check({tag, " R5 read cs addr"}, {12'b0, log_addr[4]}, {22'b0, exp_type, 2'b10});
        @(negedge clk);
        check({tag, " R8 done one cycle"}, {31'b0, done}, 32'd0);
        check({tag, " R8 back to idle"}, {31'b0, busy}, 32'd0);
    endtask

    task automatic reset_test();
        rst = 1;
        repeat (3) @(negedge clk);
        check("R9 busy in reset", {31'b0, busy}, 32'd0);
        check("R9 mem_valid in reset", {31'b0, mem_valid}, 32'd0);
        rst = 0;
        @(negedge clk);
        check("R9 done after reset", {31'b0, done}, 32'd0);
        check("R9 idle after reset", {31'b0, mem_valid}, 32'd0);
    endtask

    task automatic ignored_overflow();
        int seen;
        @(negedge clk);
        exc_ovf = 1; flags_in = 16'h0300; req = 1;
        @(negedge clk);
        clear_causes();
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            if (busy || mem_valid) seen++;
            @(negedge clk);
        end
        check("R2 overflow trap with OF clear starts nothing", seen, 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        reset_test();
        run_entry("ext21", 0, 0, 0, 0, 1, 8'h21, 16'h0B00, 16'h1234, 16'h5678, 16'h2000, 16'h0100, 8'h21, 0, 0);
        run_entry("R1 div0 wins", 1, 1, 1, 1, 1, 8'h40, 16'h0FD5, 16'hA000, 16'h0010, 16'h3000, 16'h8000, 8'h00, 1, 0);
        run_entry("R1 ovf over brk", 0, 1, 1, 1, 0, 8'h00, 16'h0800, 16'hB000, 16'h0020, 16'h3000, 16'h8000, 8'h04, 0, 0);
        run_entry("R2 ovf masked", 0, 1, 1, 0, 1, 8'h77, 16'h0200, 16'hC000, 16'h0030, 16'h3000, 16'h8000, 8'h03, 0, 0);
        ignored_overflow();
        run_entry("R1 nmi over ext", 0, 0, 0, 1, 1, 8'h99, 16'h0100, 16'hD000, 16'h0040, 16'h1000, 16'h0400, 8'h02, 3, 0);
        run_entry("R4 wrap typeFF", 0, 0, 0, 0, 1, 8'hFF, 16'hFFFF, 16'hE000, 16'h0050, 16'hFFFF, 16'h0003, 8'hFF, 2, 0);
        run_entry("R10 busy ignore", 0, 0, 0, 0, 1, 8'h10, 16'h0A00, 16'h0F0F, 16'h00F0, 16'h0800, 16'h0200, 8'h10, 3, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule